// File: doc/BRIEF.md
# Indirect 16-bit Register Access Engine

This engine gives a client a simple read/write port onto a hidden bank of 16-bit registers that can only be reached through a mailbox. For each client request it drives a short sequence of 32-bit transfers on a request/acknowledge register bus. It writes a biased address word to an address mailbox. For a write it then sends the data word. It then writes a command code. For a read it then polls a result word until that word reports ready or a bounded number of polls has been made.

The client raises `req_valid` with a direction, an address and write data. The engine takes one request at a time. It keeps `busy` high and pulses `done` once. It then presents the 16-bit result together with error and timeout flags. When a read fails, the result is the all-ones word 0xFFFF.

States: `ST_IDLE` (waits for a request), `ST_ADDR` (address mailbox transfer), `ST_WDATA` (write-data mailbox transfer, writes only), `ST_CMD` (command transfer), `ST_POLL` (repeated reads of the result word) and `ST_DONE` (one-cycle completion). Transitions: IDLE→ADDR when a request is accepted. ADDR→WDATA on acknowledge for a write. ADDR→CMD on acknowledge for a read. WDATA→CMD on acknowledge. CMD→DONE on acknowledge for a write. CMD→POLL on acknowledge for a read. POLL→DONE on an acknowledged word with ready set. POLL→DONE on the last permitted poll without ready. POLL→POLL on any other acknowledged poll. DONE→IDLE always.

Top module: `mbx_reg_engine`

## Requirements
- R1: The word written to the address mailbox (bus address 0x00) equals the requested 16-bit address shifted right by one bit, plus 0x30000.
- R2: A write request produces exactly three bus writes, in this order: the address mailbox (0x00), then the write-data mailbox (0x04) carrying the 16-bit data zero-extended, then the command mailbox (0x08) carrying the value 1.
- R3: A read request produces a bus write to the address mailbox, then a bus write of the value 2 to the command mailbox, then one or more bus reads of the result mailbox (0x0C).
- R4: Polling ends at the first acknowledged result word whose ready bit (bit 19) is 1. A ready bit seen on the last permitted poll (poll 32 by default) still counts as success.
- R5: If 32 polls complete without ready, no further poll is issued. The result is 0xFFFF with the timeout flag set and the error flag clear.
- R6: If ready is seen but the status field (bits 18:17) is not 2'b01, the result is 0xFFFF with the error flag set and the timeout flag clear.
- R7: On a successful read, the result is bits 15:0 of the final polled word, and both flags are clear. A completed write reports result 0 and both flags clear.
- R8: `busy` is high from the cycle after a request is accepted through the single cycle in which `done` is high, and low otherwise. The result outputs are valid in the `done` cycle.
- R9: A request raised while `busy` is high is ignored: it causes no bus transfer and no later completion.
- R10: Once `bus_req` is raised, it stays high with a stable address, direction and write data until `bus_ack` is seen. No bus request is made while the engine is idle.
- R11: After reset, `busy`, `done`, `bus_req` and all result flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client request strobe, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Hidden register address |
| req_wdata | input | 16 | Data for writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read result (0xFFFF on failure) |
| rsp_err | output | 1 | Status field was not OK |
| rsp_timeout | output | 1 | Poll limit exhausted |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus transfer direction, 1 = write |
| bus_addr | output | 8 | Mailbox byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus transfer acknowledge |
| bus_rdata | input | 32 | Bus read data, valid with acknowledge |

## Verification
Writes are run at an even address, an odd address and the top address, so the shift and the bias of the address word can be told apart from a plain copy. Reads are run with ready on the first poll, on a middle poll, on exactly the last permitted poll and never. This separates an off-by-one poll limit from a correct one. Ready words are given an OK status and a failing status, with junk in the upper bits, to show that only the low half is returned and that status is checked. The acknowledge latency is varied, and a request is injected while the engine is busy, to expose skipped handshakes and accidental restarts.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_CMD,
        ST_POLL,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        RES_WRITE,
        RES_OK,
        RES_ERR,
        RES_TMO
    } result_e;

    localparam logic [31:0] CMD_CODE_WRITE = 32'd1;
    localparam logic [31:0] CMD_CODE_READ  = 32'd2;
    localparam logic [15:0] FAIL_WORD      = 16'hFFFF;

endpackage

// File: rtl/mbx_poll_eval.sv
module mbx_poll_eval #(
    parameter int READY_BIT = 19,
    parameter int STAT_LSB  = 17,
    parameter int STAT_W    = 2,
    parameter logic [STAT_W-1:0] STAT_OK = 2'b01
) (
    input  logic [31:0] word,
    output logic        ready,
    output logic        ok,
    output logic [15:0] data
);
    always_comb begin
        ready = word[READY_BIT];
        ok    = (word[STAT_LSB +: STAT_W] == STAT_OK);
        data  = word[15:0];
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int POLL_LIMIT = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    is_write,
    input  logic    bus_ack,
    input  logic    poll_ready,
    input  logic    poll_ok,
    output state_e  state,
    output logic    res_load,
    output result_e res_kind
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_LIMIT - 1);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] poll_cnt;
    logic             last_poll;

    assign last_poll = (poll_cnt == LAST_POLL);
    assign state     = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_ADDR;
            ST_ADDR:  if (bus_ack) state_d = is_write ? ST_WDATA : ST_CMD;
            ST_WDATA: if (bus_ack) state_d = ST_CMD;
            ST_CMD:   if (bus_ack) state_d = is_write ? ST_DONE : ST_POLL;
            ST_POLL:  if (bus_ack && (poll_ready || last_poll)) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            poll_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_POLL)
                poll_cnt <= '0;
            else if (bus_ack && !last_poll)
                poll_cnt <= poll_cnt + 1'b1;
        end
    end

    always_comb begin
        res_load = 1'b0;
        res_kind = RES_WRITE;
        unique case (state_q)
            ST_CMD: begin
                if (bus_ack && is_write) begin
                    res_load = 1'b1;
                    res_kind = RES_WRITE;
                end
            end
            ST_POLL: begin
                if (bus_ack && poll_ready) begin
                    res_load = 1'b1;
                    res_kind = poll_ok ? RES_OK : RES_ERR;
                end else if (bus_ack && last_poll) begin
                    res_load = 1'b1;
                    res_kind = RES_TMO;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbx_bus_port.sv
module mbx_bus_port
    import mbx_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          BUS_AW    = 8,
    parameter logic [31:0] ADDR_BIAS = 32'h0003_0000,
    parameter int          OFS_ADDR  = 'h00,
    parameter int          OFS_WDATA = 'h04,
    parameter int          OFS_CMD   = 'h08,
    parameter int          OFS_RDATA = 'h0C
) (
    input  state_e            state,
    input  logic              is_write,
    input  logic [AW-1:0]     addr,
    input  logic [15:0]       wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata
);
    logic [31:0] addr_word;
    assign addr_word = (32'(addr) >> 1) + ADDR_BIAS;

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_ADDR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = BUS_AW'(OFS_ADDR);
                bus_wdata = addr_word;
            end
            ST_WDATA: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = BUS_AW'(OFS_WDATA);
                bus_wdata = {16'h0000, wdata};
            end
            ST_CMD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = BUS_AW'(OFS_CMD);
                bus_wdata = is_write ? CMD_CODE_WRITE : CMD_CODE_READ;
            end
            ST_POLL: begin
                bus_req   = 1'b1;
                bus_addr  = BUS_AW'(OFS_RDATA);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbx_reg_engine.sv
module mbx_reg_engine
    import mbx_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          BUS_AW     = 8,
    parameter int          POLL_LIMIT = 32,
    parameter logic [31:0] ADDR_BIAS  = 32'h0003_0000,
    parameter int          OFS_ADDR   = 'h00,
    parameter int          OFS_WDATA  = 'h04,
    parameter int          OFS_CMD    = 'h08,
    parameter int          OFS_RDATA  = 'h0C,
    parameter int          READY_BIT  = 19,
    parameter int          STAT_LSB   = 17,
    parameter int          STAT_W     = 2,
    parameter logic [STAT_W-1:0] STAT_OK = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rsp_data,
    output logic              rsp_err,
    output logic              rsp_timeout,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    state_e        state;
    logic          start;
    logic          res_load;
    result_e       res_kind;
    logic          lat_write;
    logic [AW-1:0] lat_addr;
    logic [15:0]   lat_wdata;
    logic          poll_ready, poll_ok;
    logic [15:0]   poll_data;

    assign start = req_valid && (state == ST_IDLE);
    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (start) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data    <= '0;
            rsp_err     <= 1'b0;
            rsp_timeout <= 1'b0;
        end else if (res_load) begin
            unique case (res_kind)
                RES_WRITE: begin rsp_data <= '0;        rsp_err <= 1'b0; rsp_timeout <= 1'b0; end
                RES_OK:    begin rsp_data <= poll_data; rsp_err <= 1'b0; rsp_timeout <= 1'b0; end
                RES_ERR:   begin rsp_data <= FAIL_WORD; rsp_err <= 1'b1; rsp_timeout <= 1'b0; end
                RES_TMO:   begin rsp_data <= FAIL_WORD; rsp_err <= 1'b0; rsp_timeout <= 1'b1; end
                default:   ;
            endcase
        end
    end

    mbx_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(lat_write),
        .bus_ack(bus_ack), .poll_ready(poll_ready), .poll_ok(poll_ok),
        .state(state), .res_load(res_load), .res_kind(res_kind)
    );

    mbx_bus_port #(
        .AW(AW), .BUS_AW(BUS_AW), .ADDR_BIAS(ADDR_BIAS), .OFS_ADDR(OFS_ADDR),
        .OFS_WDATA(OFS_WDATA), .OFS_CMD(OFS_CMD), .OFS_RDATA(OFS_RDATA)
    ) u_port (
        .state(state), .is_write(lat_write), .addr(lat_addr), .wdata(lat_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    mbx_poll_eval #(
        .READY_BIT(READY_BIT), .STAT_LSB(STAT_LSB), .STAT_W(STAT_W), .STAT_OK(STAT_OK)
    ) u_eval (
        .word(bus_rdata), .ready(poll_ready), .ok(poll_ok), .data(poll_data)
    );
endmodule

// File: rtl/mbx_reg_engine_chk.sv
module mbx_reg_engine_chk #(
    parameter int BUS_AW    = 8,
    parameter int OFS_RDATA = 'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [15:0]       rsp_data,
    input logic              rsp_err,
    input logic              rsp_timeout,
    input logic              bus_req,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R5
    tmo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_timeout) |-> (rsp_data == 16'hFFFF && !rsp_err));

    // R6
    err_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_err) |-> (rsp_data == 16'hFFFF && !rsp_timeout));

    // R3
    read_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_addr == BUS_AW'(OFS_RDATA)));
endmodule

bind mbx_reg_engine mbx_reg_engine_chk #(.BUS_AW(BUS_AW), .OFS_RDATA(OFS_RDATA)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .rsp_timeout(rsp_timeout), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_mbx_reg_engine.sv
module sim_mbx_reg_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, rsp_err, rsp_timeout;
    logic [15:0] rsp_data;
    logic        bus_req, bus_we, bus_ack;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    mbx_reg_engine u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // ---------------- target model ----------------
    int          ack_lat = 0;
    int          ready_at = 1;
    logic [1:0]  ready_stat = 2'b01;
    logic [15:0] ready_data = 16'h0;
    int          wait_cnt = 0;
    int          poll_num = 0;
    logic        seen_we[$];
    logic [7:0]  seen_addr[$];
    logic [31:0] seen_data[$];
    logic        prev_req = 1'b0;
    logic [7:0]  prev_addr = '0;
    logic [31:0] prev_wdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_rdata <= '0; wait_cnt <= 0;
        end else if (bus_req && !bus_ack) begin
            if (wait_cnt >= ack_lat) begin
                bus_ack  <= 1'b1;
                wait_cnt <= 0;
                seen_we.push_back(bus_we);
                seen_addr.push_back(bus_addr);
                seen_data.push_back(bus_wdata);
                if (bus_we && bus_addr == 8'h08) poll_num = 0;
                if (!bus_we) begin
                    poll_num = poll_num + 1;
                    if (ready_at != 0 && poll_num >= ready_at)
                        bus_rdata <= {12'hABC, 1'b1, ready_stat, 1'b1, ready_data};
                    else
                        bus_rdata <= {12'h123, 1'b0, 2'b01, 1'b0, 16'h5A5A};
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
                bus_ack  <= 1'b0;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // per-clock port comparison against protocol model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (bus_req && !busy) begin errors++; $display("FAIL R10 bus_req=%0b busy=%0b expected busy=1", bus_req, busy); end
            if (done && !busy) begin errors++; $display("FAIL R8 done=1 busy=%0b expected 1", busy); end
            if (prev_req && !bus_ack && (!bus_req || bus_addr != prev_addr || bus_wdata != prev_wdata)) begin
                errors++; $display("FAIL R10 req/addr changed before ack act=%0b/%h exp=1/%h", bus_req, bus_addr, prev_addr);
            end
            prev_req = bus_req && !bus_ack; prev_addr = bus_addr; prev_wdata = bus_wdata;
        end
    end

    // ---------------- helpers ----------------
    logic        exp_we[$];
    logic [7:0]  exp_addr[$];
    logic [31:0] exp_data[$];

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic push_exp(input logic we, input logic [7:0] a, input logic [31:0] d);
        exp_we.push_back(we); exp_addr.push_back(a); exp_data.push_back(d);
    endtask

    task automatic cmp_transfers(input string r);
        chk({r, " transfer count"}, seen_we.size(), exp_we.size());
        if (seen_we.size() == exp_we.size())
            foreach (exp_we[i]) begin
                chk({r, " dir"}, seen_we[i], exp_we[i]);
                chk({r, " addr"}, seen_addr[i], exp_addr[i]);
                if (exp_we[i]) chk({r, " wdata"}, seen_data[i], exp_data[i]);
            end
        seen_we.delete(); seen_addr.delete(); seen_data.delete();
        exp_we.delete(); exp_addr.delete(); exp_data.delete();
    endtask

    // Issue one request, wait for done, return result sampled in the done cycle.
    task automatic run_op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input bit inject, output logic [15:0] r_data,
                          output logic r_err, output logic r_tmo);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", busy, 1'b1);
        if (inject) begin
            // R9: request while busy
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hDEAD; req_wdata = 16'hBEEF;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) begin errors++; $display("FAIL R8 no done actual=0 expected=1"); end
        r_data = rsp_data; r_err = rsp_err; r_tmo = rsp_timeout;
        @(negedge clk);
        chk("R8 busy low after done", busy, 1'b0);
        chk("R8 done single cycle", done, 1'b0);
    endtask

    function automatic logic [31:0] aword(input logic [15:0] a);
        return (32'(a) >> 1) + 32'h30000;
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int lat);
        logic [15:0] rd; logic e, t;
        ack_lat = lat;
        run_op(1'b1, a, d, 1'b0, rd, e, t);
        push_exp(1'b1, 8'h00, aword(a));   // R1
        push_exp(1'b1, 8'h04, {16'h0, d});
        push_exp(1'b1, 8'h08, 32'd1);
        cmp_transfers("R2 R1 write");
        chk("R7 write rsp data", rd, 16'h0);
        chk("R7 write flags", {e, t}, 2'b00);
    endtask

    task automatic do_read(input logic [15:0] a, input int rdy, input logic [1:0] st,
                           input logic [15:0] d, input int lat, input bit inject,
                           input logic [15:0] exp_d, input logic exp_e, input logic exp_t, input string r);
        logic [15:0] rd; logic e, t; int np;
        ack_lat = lat; ready_at = rdy; ready_stat = st; ready_data = d;
        run_op(1'b0, a, 16'h0, inject, rd, e, t);
        push_exp(1'b1, 8'h00, aword(a));
        push_exp(1'b1, 8'h08, 32'd2);
        np = (rdy >= 1 && rdy <= 32) ? rdy : 32;
        for (int k = 0; k < np; k++) push_exp(1'b0, 8'h0C, 32'h0);
        cmp_transfers({r, " R3 R4 read sequence"});
        chk({r, " data"}, rd, exp_d);
        chk({r, " err"}, e, exp_e);
        chk({r, " timeout"}, t, exp_t);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 1'b0);
        chk("R11 done", done, 1'b0);
        chk("R11 bus_req", bus_req, 1'b0);
        chk("R11 flags", {rsp_err, rsp_timeout}, 2'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_write(16'h1234, 16'hCAFE, 0);               // R1 even address
        do_write(16'h0001, 16'h00FF, 2);               // R1 odd address
        do_write(16'hFFFF, 16'h8001, 1);               // R1 top address
        do_read(16'h0050, 1, 2'b01, 16'h1357, 0, 1'b0, 16'h1357, 1'b0, 1'b0, "R7 ready first");
        do_read(16'h0A0A, 4, 2'b01, 16'hBEEF, 3, 1'b0, 16'hBEEF, 1'b0, 1'b0, "R7 ready mid");
        do_read(16'h0022, 32, 2'b01, 16'h4242, 0, 1'b0, 16'h4242, 1'b0, 1'b0, "R4 ready on last poll");
        do_read(16'h0044, 0, 2'b01, 16'h0000, 1, 1'b0, 16'hFFFF, 1'b0, 1'b1, "R5 timeout");
        do_read(16'h0046, 33, 2'b01, 16'h0000, 0, 1'b0, 16'hFFFF, 1'b0, 1'b1, "R5 ready too late");
        do_read(16'h0066, 2, 2'b10, 16'h7777, 0, 1'b0, 16'hFFFF, 1'b1, 1'b0, "R6 status bad");
        do_read(16'h0068, 3, 2'b00, 16'h7777, 2, 1'b0, 16'hFFFF, 1'b1, 1'b0, "R6 status zero");
        do_read(16'h0100, 6, 2'b01, 16'hA5C3, 2, 1'b1, 16'hA5C3, 1'b0, 1'b0, "R9 busy request ignored");

        // R9: no completion or transfer after the injected request
        repeat (10) @(negedge clk);
        chk("R9 stays idle", busy, 1'b0);
        chk("R9 no extra transfer", seen_we.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule